// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Target

This block loads a configuration image into a downstream programmable device through a bit-serial slave port. It drives three outputs toward the target: an active-low program line, a configuration clock and a serial data line. It watches two status inputs from the target, init and done. Both inputs pass through a two-flop synchroniser before any decision uses them.

A start pulse taken while the block is idle opens a sequence. The block holds program low until the target pulls init low, then releases program and waits for init to come back high. Next it accepts image bytes on a valid/ready stream and clocks each byte out most significant bit first. Each bit takes four equal steps. After the byte flagged last has gone out, the block waits for done.

Each of the three waits has its own timeout. The timeout is a number of poll intervals, and a prescaler counted in system clocks sets the length of each interval. The outcome is either success or one of three failure codes. It stays on the outputs until the next start.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, prog_n_o, cclk_o and cdata_o are high. busy_o, ok_o, err_o and byte_ready_o are low, and err_code_o is 0.
- R2: A start_i pulse in idle drives prog_n_o low on the next cycle and raises busy_o. cclk_o and cdata_o stay high while prog_n_o is low. A sequence produces exactly one low period on prog_n_o.
- R3: If the synchronised init input does not go low within MAX_POLLS poll intervals of TICK_DIV clocks each, the sequence ends with err_o high and err_code_o = 1. prog_n_o is low for MAX_POLLS*TICK_DIV+1 cycles, within two cycles, and then returns high. No bit is clocked out.
- R4: Once init is seen low, prog_n_o goes high. If init does not return high within the same timeout, the sequence ends with err_code_o = 2 and no bit is clocked out.
- R5: Each bit occupies four steps of STEP_CYCLES clocks each. In order: clock low with data high; clock low with data set to the bit; clock high with the bit held; clock high with data high. Data never changes on a rising edge of cclk_o, and data is high just before every falling edge.
- R6: Bits are sent most significant bit first, and bytes are sent in the order they were accepted. Every bit of every byte appears once on a rising edge of cclk_o.
- R7: A byte is taken (byte_valid_i and byte_ready_o high at a clock edge) only between bytes while the data phase is active. Whenever byte_ready_o is high, cclk_o is low and cdata_o is high, so a stalled stream parks the clock low and the data high.
- R8: After the byte flagged by byte_last_i has been sent, cclk_o rests low with cdata_o high. If done does not go high within the timeout, the sequence ends with err_code_o = 3.
- R9: If done is seen high in that final wait, the sequence ends with ok_o high, err_o low and err_code_o = 0.
- R10: start_i has no effect while busy_o is high. After busy_o falls, ok_o, err_o and err_code_o hold their values, and prog_n_o, cclk_o and cdata_o stay high, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| byte_data_i | input | BYTE_W | Image byte |
| byte_valid_i | input | 1 | Image byte is valid |
| byte_last_i | input | 1 | Marks the final image byte |
| byte_ready_o | output | 1 | Block takes a byte at this edge if valid |
| prog_n_o | output | 1 | Active-low program line to target |
| cclk_o | output | 1 | Configuration clock to target |
| cdata_o | output | 1 | Serial configuration data to target |
| tgt_init_i | input | 1 | Target init status (asynchronous) |
| tgt_done_i | input | 1 | Target done status (asynchronous) |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last sequence succeeded |
| err_o | output | 1 | Last sequence failed |
| err_code_o | output | 2 | 0 none, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The bench builds the block with TICK_DIV = 4 and MAX_POLLS = 4, so every timeout expires after 16 clocks. This lets all three failure codes and their exact cycle windows appear in a short run. STEP_CYCLES = 2 selects the counted-step variant of the shifter, so every bit step lasts several samples and hold and park violations become visible. Byte counts of 1 to 12, random stalls and repeated start pulses test the flow control and the start-ignored rule.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PROG,
      PH_INIT_REL,
      PH_SHIFT,
      PH_DONE_WAIT
   } phase_t;

   typedef enum logic [1:0] {
      RC_NONE      = 2'd0,
      RC_INIT_LOW  = 2'd1,
      RC_INIT_HIGH = 2'd2,
      RC_DONE      = 2'd3
   } result_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned      WIDTH   = 2,
   parameter int unsigned      STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cfg_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
   parameter int unsigned TICK_DIV  = 50000,
   parameter int unsigned MAX_POLLS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   output logic expired_o
);

   localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam int unsigned PW = $clog2(MAX_POLLS + 1);
   localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
   localparam logic [PW-1:0] POLL_LIM  = PW'(MAX_POLLS);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("cfg_poll_timer: TICK_DIV must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("cfg_poll_timer: MAX_POLLS must be at least 1");
      end
   endgenerate

   logic [TW-1:0] tick_q;
   logic [PW-1:0] poll_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         poll_q <= '0;
      end else if (clear_i) begin
         tick_q <= '0;
         poll_q <= '0;
      end else if (poll_q != POLL_LIM) begin
         if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            poll_q <= poll_q + 1'b1;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assign expired_o = (poll_q == POLL_LIM);

   // R3: an expired window stays expired until the owner restarts it
   assert_expire_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !clear_i) |=> expired_o);

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned STEP_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              valid_i,
   output logic              ready_o,
   output logic              busy_o,
   output logic              cclk_o,
   output logic              cdata_o
);

   localparam int unsigned BW = $clog2(BYTE_W);

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("cfg_bit_shifter: BYTE_W must be at least 2");
      end
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("cfg_bit_shifter: STEP_CYCLES must be at least 1");
      end
   endgenerate

   logic              busy_q;
   logic [BYTE_W-1:0] sreg_q;
   logic [BW-1:0]     bits_left_q;
   logic [1:0]        step_q;
   logic              step_end;

   generate
      if (STEP_CYCLES == 1) begin : g_fast
         assign step_end = busy_q;
      end else begin : g_slow
         localparam int unsigned SW = $clog2(STEP_CYCLES);
         localparam logic [SW-1:0] DWELL_LAST = SW'(STEP_CYCLES - 1);
         logic [SW-1:0] dwell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dwell_q <= '0;
            end else if (!busy_q || dwell_q == DWELL_LAST) begin
               dwell_q <= '0;
            end else begin
               dwell_q <= dwell_q + 1'b1;
            end
         end
         assign step_end = busy_q && (dwell_q == DWELL_LAST);
      end
   endgenerate

   assign ready_o = enable_i && !busy_q;
   assign busy_o  = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         sreg_q      <= '0;
         bits_left_q <= '0;
         step_q      <= 2'd0;
      end else if (!busy_q) begin
         if (valid_i && ready_o) begin
            busy_q      <= 1'b1;
            sreg_q      <= data_i;
            bits_left_q <= BW'(BYTE_W - 1);
            step_q      <= 2'd0;
         end
      end else if (step_end) begin
         if (step_q == 2'd3) begin
            step_q <= 2'd0;
            if (bits_left_q == '0) begin
               busy_q <= 1'b0;
            end else begin
               bits_left_q <= bits_left_q - 1'b1;
               sreg_q      <= {sreg_q[BYTE_W-2:0], 1'b0};
            end
         end else begin
            step_q <= step_q + 2'd1;
         end
      end
   end

   always_comb begin
      cclk_o  = 1'b0;
      cdata_o = 1'b1;
      if (busy_q) begin
         unique case (step_q)
            2'd0: begin cclk_o = 1'b0; cdata_o = 1'b1;             end
            2'd1: begin cclk_o = 1'b0; cdata_o = sreg_q[BYTE_W-1]; end
            2'd2: begin cclk_o = 1'b1; cdata_o = sreg_q[BYTE_W-1]; end
            default: begin cclk_o = 1'b1; cdata_o = 1'b1;          end
         endcase
      end
   end

   // R5: data is held across every rising clock edge
   assert_data_held_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk_o) |-> $stable(cdata_o));

   // R5: data is back high before every falling clock edge
   assert_data_high_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cclk_o) |-> $past(cdata_o));

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
   import cfg_seq_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned TICK_DIV    = 50000,
   parameter int unsigned MAX_POLLS   = 4,
   parameter int unsigned STEP_CYCLES = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] byte_data_i,
   input  logic              byte_valid_i,
   input  logic              byte_last_i,
   output logic              byte_ready_o,
   output logic              prog_n_o,
   output logic              cclk_o,
   output logic              cdata_o,
   input  logic              tgt_init_i,
   input  logic              tgt_done_i,
   output logic              busy_o,
   output logic              ok_o,
   output logic              err_o,
   output logic [1:0]        err_code_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fpga_cfg_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // synchronised target status: bit 0 init, bit 1 done
   logic [1:0] tgt_s;
   logic       init_s;
   logic       done_s;

   cfg_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(2'b01)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i({tgt_done_i, tgt_init_i}),
      .sync_o (tgt_s)
   );

   assign init_s = tgt_s[0];
   assign done_s = tgt_s[1];

   phase_t  phase_q, phase_d;
   logic    last_seen_q;
   logic    ok_q, err_q;
   result_t code_q;
   logic    fin_ok, fin_err;
   result_t fin_code;
   logic    expired;
   logic    timer_clr;

   logic    sh_enable, sh_ready, sh_busy, sh_clk, sh_dat;

   assign timer_clr = (phase_d != phase_q);

   cfg_poll_timer #(
      .TICK_DIV (TICK_DIV),
      .MAX_POLLS(MAX_POLLS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (timer_clr),
      .expired_o(expired)
   );

   assign sh_enable = (phase_q == PH_SHIFT) && !last_seen_q;

   cfg_bit_shifter #(
      .BYTE_W     (BYTE_W),
      .STEP_CYCLES(STEP_CYCLES)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable_i(sh_enable),
      .data_i  (byte_data_i),
      .valid_i (byte_valid_i),
      .ready_o (sh_ready),
      .busy_o  (sh_busy),
      .cclk_o  (sh_clk),
      .cdata_o (sh_dat)
   );

   always_comb begin
      phase_d  = phase_q;
      fin_ok   = 1'b0;
      fin_err  = 1'b0;
      fin_code = RC_NONE;
      unique case (phase_q)
         PH_IDLE: begin
            if (start_i) phase_d = PH_PROG;
         end
         PH_PROG: begin
            if (!init_s) begin
               phase_d = PH_INIT_REL;
            end else if (expired) begin
               phase_d  = PH_IDLE;
               fin_err  = 1'b1;
               fin_code = RC_INIT_LOW;
            end
         end
         PH_INIT_REL: begin
            if (init_s) begin
               phase_d = PH_SHIFT;
            end else if (expired) begin
               phase_d  = PH_IDLE;
               fin_err  = 1'b1;
               fin_code = RC_INIT_HIGH;
            end
         end
         PH_SHIFT: begin
            if (last_seen_q && !sh_busy) phase_d = PH_DONE_WAIT;
         end
         PH_DONE_WAIT: begin
            if (done_s) begin
               phase_d = PH_IDLE;
               fin_ok  = 1'b1;
            end else if (expired) begin
               phase_d  = PH_IDLE;
               fin_err  = 1'b1;
               fin_code = RC_DONE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         last_seen_q <= 1'b0;
         ok_q        <= 1'b0;
         err_q       <= 1'b0;
         code_q      <= RC_NONE;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_IDLE && start_i) begin
            last_seen_q <= 1'b0;
            ok_q        <= 1'b0;
            err_q       <= 1'b0;
            code_q      <= RC_NONE;
         end
         if (byte_valid_i && sh_ready && byte_last_i) last_seen_q <= 1'b1;
         if (fin_ok) ok_q <= 1'b1;
         if (fin_err) begin
            err_q  <= 1'b1;
            code_q <= fin_code;
         end
      end
   end

   assign byte_ready_o = sh_ready;
   assign prog_n_o     = (phase_q != PH_PROG);
   assign cclk_o       = (phase_q == PH_SHIFT)     ? sh_clk :
                         (phase_q == PH_DONE_WAIT) ? 1'b0   : 1'b1;
   assign cdata_o      = (phase_q == PH_SHIFT) ? sh_dat : 1'b1;
   assign busy_o       = (phase_q != PH_IDLE);
   assign ok_o         = ok_q;
   assign err_o        = err_q;
   assign err_code_o   = code_q;

   // R2: program falls only out of idle, with clock and data high
   assert_prog_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_n_o) |-> (cclk_o && cdata_o && $past(!busy_o)));

   // R3: code 1 only ends a program-low phase
   assert_init_low_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(err_o) && err_code_o == 2'd1) |-> $past(!prog_n_o));

   // R4: code 2 only after program release while init is still low
   assert_init_high_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(err_o) && err_code_o == 2'd2) |-> ($past(prog_n_o) && $past(!init_s)));

   // R7: offering to take a byte implies the parked pin shape
   assert_stall_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready_o |-> (!cclk_o && cdata_o));

   // R8: code 3 only ends the final wait, where the clock rests low
   assert_done_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(err_o) && err_code_o == 2'd3) |-> $past(!cclk_o));

   // R9: success follows a seen done and never coexists with failure
   assert_ok_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_o) |-> ($past(done_s) && !err_o));

   // R10: results hold while idle
   assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> ($stable(err_code_o) && $stable(ok_o) && $stable(err_o)));

endmodule

// File: tb/fpga_cfg_seq_bench.sv
`timescale 1ns/1ps
module fpga_cfg_seq_bench;

   localparam int BYTE_W   = 8;
   localparam int TICK_DIV = 4;
   localparam int POLLS    = 4;
   localparam int STEPS    = 2;
   localparam int TO_CYC   = TICK_DIV * POLLS;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n, start_i, byte_valid_i, byte_last_i;
   logic [BYTE_W-1:0] byte_data_i;
   logic              byte_ready_o, prog_n_o, cclk_o, cdata_o;
   logic              init_m, done_m;
   logic              busy_o, ok_o, err_o;
   logic [1:0]        err_code_o;

   fpga_cfg_seq #(
      .BYTE_W(BYTE_W), .TICK_DIV(TICK_DIV), .MAX_POLLS(POLLS),
      .STEP_CYCLES(STEPS), .SYNC_STAGES(2)
   ) u_fpga_cfg_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
      .byte_last_i(byte_last_i), .byte_ready_o(byte_ready_o),
      .prog_n_o(prog_n_o), .cclk_o(cclk_o), .cdata_o(cdata_o),
      .tgt_init_i(init_m), .tgt_done_i(done_m),
      .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .err_code_o(err_code_o)
   );

   int n_run  = 0;
   int n_fail = 0;

   // target model and stream settings
   bit   cfg_drop, cfg_rel, cfg_done, feeding;
   int   cfg_stall;
   logic [7:0] img [16];
   logic [7:0] got [16];
   int   img_n, feed_idx, got_bits, prog_falls, prog_low_len, stall_bad, r5_bad;
   bit   prev_xfer, prev_clk, prev_dat, prev_prog;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         // monitor
         if (busy_o && cclk_o && !prev_clk) begin
            if (got_bits < 128) got[got_bits/8][7 - got_bits%8] = cdata_o;
            got_bits++;
            if (cdata_o != prev_dat) r5_bad++;
         end
         if (busy_o && !cclk_o && prev_clk && !prev_dat) r5_bad++;
         if (!prog_n_o && prev_prog) prog_falls++;
         if (!prog_n_o) prog_low_len++;
         if (byte_ready_o && !(cclk_o == 1'b0 && cdata_o == 1'b1)) stall_bad++;
         prev_clk  = cclk_o;
         prev_dat  = cdata_o;
         prev_prog = prog_n_o;
         // target model
         if (!prog_n_o) begin
            done_m = 1'b0;
            if (cfg_drop) init_m = 1'b0;
         end else if (!init_m && cfg_rel) begin
            init_m = 1'b1;
         end
         if (cfg_done && img_n > 0 && got_bits == img_n * 8) done_m = 1'b1;
         // byte feeder
         if (feeding) begin
            if (prev_xfer) feed_idx++;
            if (feed_idx < img_n && int'($urandom % 100) >= cfg_stall) begin
               byte_valid_i = 1'b1;
               byte_data_i  = img[feed_idx];
               byte_last_i  = (feed_idx == img_n - 1);
            end else begin
               byte_valid_i = 1'b0;
               byte_data_i  = 8'($urandom);
               byte_last_i  = 1'b0;
            end
            prev_xfer = byte_valid_i && byte_ready_o;
         end
      end
   end

   task automatic run_seq(input int n, input bit drop, input bit rel, input bit dn,
                          input int stall, input bit poke, input int pat);
      int exp_code;
      int w;
      logic [1:0] held;
      exp_code = !drop ? 1 : (!rel ? 2 : (!dn ? 3 : 0));
      for (int i = 0; i < 16; i++) begin
         got[i] = 8'h00;
         case (pat)
            1: img[i] = (i % 4 == 0) ? 8'h80 : (i % 4 == 1) ? 8'h01 : (i % 4 == 2) ? 8'hFF : 8'h00;
            default: img[i] = 8'($urandom);
         endcase
      end
      img_n = n; feed_idx = 0; got_bits = 0; prog_falls = 0; prog_low_len = 0;
      stall_bad = 0; r5_bad = 0; prev_xfer = 1'b0;
      cfg_drop = drop; cfg_rel = rel; cfg_done = dn; cfg_stall = stall;
      init_m = 1'b1; done_m = 1'b0; feeding = 1'b1;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R2", "busy after start", int'(busy_o), 1);
      chk("R2", "prog_n low after start", int'(prog_n_o), 0);
      chk("R2", "clock and data high during program", int'(cclk_o && cdata_o), 1);
      if (poke) begin
         repeat (30) @(negedge clk);
         start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      end
      w = 0;
      while (busy_o && w < 20000) begin @(negedge clk); w++; end
      feeding = 1'b0; byte_valid_i = 1'b0; byte_last_i = 1'b0;
      case (exp_code)
         1: chk("R3", "error code", int'(err_code_o), 1);
         2: chk("R4", "error code", int'(err_code_o), 2);
         3: chk("R8", "error code", int'(err_code_o), 3);
         default: chk("R9", "error code", int'(err_code_o), 0);
      endcase
      chk("R9", "ok flag", int'(ok_o), int'(exp_code == 0));
      chk("R9", "err flag", int'(err_o), int'(exp_code != 0));
      chk(poke ? "R10" : "R2", "program pulses", prog_falls, 1);
      chk("R7", "parked shape while ready", stall_bad, 0);
      chk("R5", "four-step violations", r5_bad, 0);
      if (exp_code == 1) begin
         chk("R3", "program low window ok", int'(prog_low_len >= TO_CYC && prog_low_len <= TO_CYC + 3), 1);
         chk("R3", "bits sent", got_bits, 0);
      end else if (exp_code == 2) begin
         chk("R4", "program released early", int'(prog_low_len < TO_CYC), 1);
         chk("R4", "bits sent", got_bits, 0);
      end else begin
         chk("R6", "bit count", got_bits, n * 8);
         for (int i = 0; i < n; i++) chk("R6", "byte value", int'(got[i]), int'(img[i]));
      end
      held = err_code_o;
      start_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R10", "code held", int'(err_code_o), int'(held));
      chk("R10", "idle pins high", int'(prog_n_o && cclk_o && cdata_o && !busy_o), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      rst_n = 1'b0; start_i = 1'b0; byte_valid_i = 1'b0; byte_last_i = 1'b0;
      byte_data_i = '0; init_m = 1'b1; done_m = 1'b0; feeding = 1'b0;
      cfg_drop = 1'b0; cfg_rel = 1'b0; cfg_done = 1'b0; cfg_stall = 0;
      img_n = 0; prev_clk = 1'b1; prev_dat = 1'b1; prev_prog = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset pins high", int'(prog_n_o && cclk_o && cdata_o), 1);
      chk("R1", "reset flags low", int'(busy_o || ok_o || err_o || byte_ready_o), 0);
      chk("R1", "reset code", int'(err_code_o), 0);
      run_seq(3, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);   // init never falls
      run_seq(2, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);   // init never returns
      run_seq(2, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1);   // done never rises
      run_seq(4, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1);   // edge bytes, no stall
      run_seq(1, 1'b1, 1'b1, 1'b1, 0, 1'b0, 0);   // single byte
      run_seq(5, 1'b1, 1'b1, 1'b1, 60, 1'b1, 0);  // stalls and start while busy
      for (int k = 0; k < 8; k++) begin
         run_seq(1 + int'($urandom % 12), 1'b1, 1'b1, ($urandom % 4) != 0,
                 int'($urandom % 70), k[0], 0);
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule